// File: doc/BRIEF.md
# RTC Supervisory Status Register

This block keeps the supervisory state of a real-time clock: a sticky power-up flag, an oscillator-health bit, a sticky supply-drop flag with its threshold choice, and two clock-output disable bits that sit in two different registers. Analog detection stays outside. The block receives a power-up-from-zero pulse, a raw oscillator-halt signal, a once-per-second sample strobe and the result of a supply comparator. It returns the readable register images, a clear strobe for neighbouring control logic, a monitor-active line and the clock-output enable.

A three-state machine drives the behaviour. In `ST_HOLD` the power-up flag is set, and the trim register and both control registers are held at zero. In `ST_WATCH` the supply monitor takes a sample on each strobe. In `ST_TRIP` the drop flag is set and sampling stops. The machine has these transitions:
- HOLD_TO_WATCH: a write that clears the power-up flag.
- WATCH_TO_TRIP: a low sample.
- TRIP_TO_WATCH: a write that clears the drop flag.
- ANY_TO_HOLD: a power-up pulse.

There are three registers, each at its own address: trim (`ADJ_ADDR`), control A (`CTLA_ADDR`) and control B (`CTLB_ADDR`). Control B has this layout: bit 0 threshold select, bit 1 drop flag, bit 2 oscillator-ok, bit 3 clock-off B, bit 4 power-up flag, bits 7:5 plain storage. Control A has clock-off A at bit 4, and its other bits are plain storage.

Top module: `rtc_sup_status`

## Requirements
- R1: After reset, and one cycle after a `por_pulse`, `ctlb_q[4]` reads 1 and `ctl_clear` is 1. `ctlb_q[1]` reads 0.
- R2: The power-up flag `ctlb_q[4]` clears only on a write to control B with data bit 4 = 0. A write with bit 4 = 1 leaves it at 1.
- R3: While the power-up flag is 1, `adj_q` and `ctla_q` read 0, and every bit of `ctlb_q` other than 2 and 4 reads 0. Writes to those bits are ignored. A `por_pulse` zeroes all of them.
- R4: `ctlb_q[2]` (oscillator-ok) is forced to 0 on the third rising edge after `osc_halt_async` rises, and it stays 0 while the halt persists. Otherwise a write to control B loads it from data bit 2, in any state. `por_pulse` does not change it. Reset value is 0.
- R5: In `ST_WATCH`, a clock edge that sees `sec_tick` = 1 and `vdd_below` = 1 together sets `ctlb_q[1]`. `vdd_below` without `sec_tick` has no effect.
- R6: While `ctlb_q[1]` is 1, `mon_active` is 0, samples are ignored, and writing 1 to bit 1 has no effect. Writing 0 to bit 1 clears the flag and returns `mon_active` to 1.
- R7: In `ST_TRIP`, a clearing write wins over a low sample in the same cycle. In `ST_WATCH`, a low sample sets the flag even if the same cycle writes 0 to bit 1.
- R8: `thresh_sel` equals `ctlb_q[0]`.
- R9: `clkout_en` is 0 only when both `ctla_q[4]` and `ctlb_q[3]` are 1.
- R10: A write changes only the register at its address. A write to any other address changes nothing.
- R11: A `por_pulse` takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_pulse | input | 1 | Power-up-from-zero pulse |
| osc_halt_async | input | 1 | Raw oscillator-halt detect, asynchronous |
| sec_tick | input | 1 | Once-per-second supply sample strobe |
| vdd_below | input | 1 | Comparator result, 1 = supply below threshold |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| adj_q | output | DW | Trim register image |
| ctla_q | output | DW | Control A image |
| ctlb_q | output | DW | Control B image, including status bits |
| ctl_clear | output | 1 | Clear strobe to neighbouring control registers |
| mon_active | output | 1 | Supply monitor is sampling |
| thresh_sel | output | 1 | Threshold choice forwarded to the comparator |
| clkout_en | output | 1 | 32 kHz output enable |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a supply sample and a drop-flag write. The bench provokes this by raising `sec_tick` with `vdd_below` high in the same cycle as a control-B write of bit 1 = 0, once from `ST_WATCH` and once from `ST_TRIP`. It expects the flag to be set in the first case and cleared in the second. The second pair is a power-up pulse and a register write, driven on one edge. The bench expects the power-up flag set and the written register zero. A behavioural model checks every output on every cycle, including through a phase of random stimulus.

// File: rtl/rtc_sup_pkg.sv
package rtc_sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_WATCH = 2'd1,
        ST_TRIP  = 2'd2
    } sup_state_t;

    // control B bit positions
    localparam int CB_THR = 0;
    localparam int CB_VF  = 1;
    localparam int CB_OSC = 2;
    localparam int CB_CLK = 3;
    localparam int CB_PWR = 4;
    // control A bit position
    localparam int CA_CLK = 4;

endpackage

// File: rtl/rtc_sup_sync.sv
module rtc_sup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[0] <= 1'b0;
                    else        sh[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[i] <= 1'b0;
                    else        sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/rtc_sup_fsm.sv
module rtc_sup_fsm
    import rtc_sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por_pulse,
    input  logic sample_tick,
    input  logic below_thr,
    input  logic clr_pwr_req,
    input  logic clr_vf_req,
    output logic hold_o,
    output logic mon_active_o,
    output logic vflag_o
);
    sup_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (por_pulse) begin
            nxt = ST_HOLD;                       // ANY_TO_HOLD
        end else begin
            unique case (state)
                ST_HOLD:  if (clr_pwr_req) nxt = ST_WATCH;              // HOLD_TO_WATCH
                ST_WATCH: if (sample_tick && below_thr) nxt = ST_TRIP;  // WATCH_TO_TRIP
                ST_TRIP:  if (clr_vf_req) nxt = ST_WATCH;               // TRIP_TO_WATCH
                default:  nxt = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        hold_o       = 1'b0;
        mon_active_o = 1'b0;
        vflag_o      = 1'b0;
        unique case (state)
            ST_HOLD:  hold_o       = 1'b1;
            ST_WATCH: mon_active_o = 1'b1;
            ST_TRIP:  vflag_o      = 1'b1;
            default:  hold_o       = 1'b1;
        endcase
    end

    assert_por_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |=> state == ST_HOLD);
    assert_pwr_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !clr_pwr_req) |=> state == ST_HOLD);
    assert_sample_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && sample_tick && below_thr && !por_pulse) |=> state == ST_TRIP);
    assert_trip_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && !clr_vf_req && !por_pulse) |=> state == ST_TRIP);
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && clr_vf_req && !por_pulse) |=> state == ST_WATCH);
endmodule

// File: rtl/rtc_sup_regs.sv
module rtc_sup_regs
    import rtc_sup_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_pulse,
    input  logic          hold,
    input  logic          halt_s,
    input  logic          we_adj,
    input  logic          we_ctla,
    input  logic          we_ctlb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] adj_q,
    output logic [DW-1:0] ctla_q,
    output logic [DW-1:0] store_b_q,
    output logic          osc_ok_q
);
    localparam logic [DW-1:0] STATUS_BITS =
        (DW'(1) << CB_VF) | (DW'(1) << CB_OSC) | (DW'(1) << CB_PWR);
    localparam logic [DW-1:0] STORE_MASK = ~STATUS_BITS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adj_q     <= '0;
            ctla_q    <= '0;
            store_b_q <= '0;
        end else if (por_pulse) begin
            adj_q     <= '0;
            ctla_q    <= '0;
            store_b_q <= '0;
        end else if (!hold) begin
            if (we_adj)  adj_q     <= wdata;
            if (we_ctla) ctla_q    <= wdata;
            if (we_ctlb) store_b_q <= wdata & STORE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       osc_ok_q <= 1'b0;
        else if (halt_s)  osc_ok_q <= 1'b0;
        else if (we_ctlb) osc_ok_q <= wdata[CB_OSC];
    end

    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (adj_q == '0 && ctla_q == '0 && store_b_q == '0));
    assert_halt_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
        halt_s |=> !osc_ok_q);
    assert_addr_isolation_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_adj && !por_pulse) |=> $stable(ctla_q));
endmodule

// File: rtl/rtc_sup_status.sv
module rtc_sup_status
    import rtc_sup_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter logic [AW-1:0] ADJ_ADDR  = AW'(2),
    parameter logic [AW-1:0] CTLA_ADDR = AW'(5),
    parameter logic [AW-1:0] CTLB_ADDR = AW'(9),
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_pulse,
    input  logic          osc_halt_async,
    input  logic          sec_tick,
    input  logic          vdd_below,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] adj_q,
    output logic [DW-1:0] ctla_q,
    output logic [DW-1:0] ctlb_q,
    output logic          ctl_clear,
    output logic          mon_active,
    output logic          thresh_sel,
    output logic          clkout_en
);
    logic we_adj, we_ctla, we_ctlb;
    logic halt_s, hold, vflag, osc_ok;
    logic [DW-1:0] store_b;

    assign we_adj  = wr_en && (wr_addr == ADJ_ADDR);
    assign we_ctla = wr_en && (wr_addr == CTLA_ADDR);
    assign we_ctlb = wr_en && (wr_addr == CTLB_ADDR);

    rtc_sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (osc_halt_async),
        .dout (halt_s)
    );

    rtc_sup_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_pulse   (por_pulse),
        .sample_tick (sec_tick),
        .below_thr   (vdd_below),
        .clr_pwr_req (we_ctlb && !wr_data[CB_PWR]),
        .clr_vf_req  (we_ctlb && !wr_data[CB_VF]),
        .hold_o      (hold),
        .mon_active_o(mon_active),
        .vflag_o     (vflag)
    );

    rtc_sup_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_pulse(por_pulse),
        .hold     (hold),
        .halt_s   (halt_s),
        .we_adj   (we_adj),
        .we_ctla  (we_ctla),
        .we_ctlb  (we_ctlb),
        .wdata    (wr_data),
        .adj_q    (adj_q),
        .ctla_q   (ctla_q),
        .store_b_q(store_b),
        .osc_ok_q (osc_ok)
    );

    always_comb begin
        ctlb_q         = store_b;
        ctlb_q[CB_VF]  = vflag;
        ctlb_q[CB_OSC] = osc_ok;
        ctlb_q[CB_PWR] = hold;
    end

    assign ctl_clear  = hold;
    assign thresh_sel = store_b[CB_THR];
    assign clkout_en  = ~(ctla_q[CA_CLK] & store_b[CB_CLK]);

    assert_clk_on_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> clkout_en);
    assert_por_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (por_pulse && wr_en) |=> (ctl_clear && adj_q == '0));
endmodule

// File: tb/rtc_sup_status_tb_top.sv
module rtc_sup_status_tb_top;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam logic [3:0] A_ADJ  = 4'h2;
    localparam logic [3:0] A_CTLA = 4'h5;
    localparam logic [3:0] A_CTLB = 4'h9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_pulse = 0, osc_halt_async = 0, sec_tick = 0, vdd_below = 0, wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] adj_q, ctla_q, ctlb_q;
    logic ctl_clear, mon_active, thresh_sel, clkout_en;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    rtc_sup_status dut_i (
        .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .osc_halt_async(osc_halt_async),
        .sec_tick(sec_tick), .vdd_below(vdd_below), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .adj_q(adj_q), .ctla_q(ctla_q), .ctlb_q(ctlb_q),
        .ctl_clear(ctl_clear), .mon_active(mon_active), .thresh_sel(thresh_sel),
        .clkout_en(clkout_en)
    );

    // behavioural reference model
    int m_pwr, m_vf, m_osc, m_adj, m_ctla, m_store;
    bit hq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pwr = 1; m_vf = 0; m_osc = 0; m_adj = 0; m_ctla = 0; m_store = 0;
            hq = '{0, 0};
        end else begin
            bit old_halt;
            bit wb;
            old_halt = hq[0];
            void'(hq.pop_front());
            hq.push_back(osc_halt_async);
            wb = wr_en && (wr_addr == A_CTLB);
            if (old_halt) m_osc = 0;
            else if (wb) m_osc = wr_data[2];
            if (por_pulse) begin
                m_pwr = 1; m_vf = 0; m_adj = 0; m_ctla = 0; m_store = 0;
            end else if (m_pwr == 1) begin
                if (wb && !wr_data[4]) m_pwr = 0;
            end else begin
                if (m_vf == 1) begin
                    if (wb && !wr_data[1]) m_vf = 0;
                end else if (sec_tick && vdd_below) m_vf = 1;
                if (wr_en && wr_addr == A_ADJ)  m_adj = wr_data;
                if (wr_en && wr_addr == A_CTLA) m_ctla = wr_data;
                if (wb) m_store = wr_data & 8'hE9;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int eb;
            eb = m_store | (m_vf << 1) | (m_osc << 2) | (m_pwr << 4);
            chk("R3", "adj_q", adj_q, m_adj);
            chk("R10", "ctla_q", ctla_q, m_ctla);
            chk("R2", "ctlb_q", ctlb_q, eb);
            chk("R1", "ctl_clear", ctl_clear, m_pwr);
            chk("R6", "mon_active", mon_active, (m_pwr == 0 && m_vf == 0) ? 1 : 0);
            chk("R8", "thresh_sel", thresh_sel, m_store & 1);
            chk("R9", "clkout_en", clkout_en, (m_ctla[4] && m_store[3]) ? 0 : 1);
        end
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        chk("R1", "reset ctlb", ctlb_q, 8'h10);
        chk("R1", "reset ctl_clear", ctl_clear, 1);

        wr(A_CTLA, 8'hFF);
        chk("R3", "ctla write in hold", ctla_q, 0);
        wr(A_CTLB, 8'hFF);
        chk("R2", "write 1 to pwr", ctlb_q, 8'h14);
        wr(A_CTLB, 8'h04);
        chk("R2", "pwr cleared", ctlb_q, 8'h04);

        wr(A_ADJ, 8'h5A);
        wr(A_CTLA, 8'h10);
        chk("R10", "adj kept", adj_q, 8'h5A);
        chk("R9", "one off bit", clkout_en, 1);
        wr(A_CTLB, 8'h0D);
        chk("R9", "both off bits", clkout_en, 0);
        chk("R8", "thresh", thresh_sel, 1);
        wr(4'h7, 8'hFF);
        chk("R10", "unmapped write", ctlb_q, 8'h0D);

        vdd_below = 1; idle(3);
        chk("R5", "low without tick", ctlb_q[1], 0);
        sec_tick = 1; idle(1); sec_tick = 0;
        chk("R5", "tick trips", ctlb_q[1], 1);
        chk("R6", "monitor stops", mon_active, 0);
        wr(A_CTLB, 8'h0F);
        chk("R6", "write 1 to vflag", ctlb_q[1], 1);
        wr(A_CTLB, 8'h0D);
        chk("R6", "clear vflag", ctlb_q[1], 0);
        chk("R6", "monitor resumes", mon_active, 1);

        sec_tick = 1; wr(A_CTLB, 8'h0D); sec_tick = 0;
        chk("R7", "sample beats write in watch", ctlb_q[1], 1);
        sec_tick = 1; wr(A_CTLB, 8'h0D); sec_tick = 0;
        chk("R7", "clear beats sample in trip", ctlb_q[1], 0);
        vdd_below = 0;

        osc_halt_async = 1; idle(2);
        chk("R4", "sync latency", ctlb_q[2], 1);
        idle(1);
        chk("R4", "halt forces 0", ctlb_q[2], 0);
        wr(A_CTLB, 8'h0D);
        chk("R4", "write during halt", ctlb_q[2], 0);
        osc_halt_async = 0; idle(3);
        wr(A_CTLB, 8'h0D);
        chk("R4", "osc set by write", ctlb_q[2], 1);

        por_pulse = 1; wr(A_ADJ, 8'h33); por_pulse = 0;
        chk("R11", "por beats write", adj_q, 0);
        chk("R11", "por sets flag", ctlb_q, 8'h14);

        wr(A_CTLB, 8'h00);
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 63);
            por_pulse = (r == 0);
            sec_tick = ($urandom_range(0, 3) == 0);
            vdd_below = $urandom_range(0, 1);
            if ($urandom_range(0, 31) == 0) osc_halt_async = ~osc_halt_async;
            wr_en = ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 3))
                0: wr_addr = A_ADJ;
                1: wr_addr = A_CTLA;
                2: wr_addr = A_CTLB;
                default: wr_addr = 4'hC;
            endcase
            wr_data = 8'($urandom);
            @(negedge clk);
        end
        por_pulse = 0; sec_tick = 0; wr_en = 0;
        idle(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule